// File: doc/BRIEF.md
# I2C master command sequencer

This block sits between a host and a bit-level I2C engine. The host pushes 11-bit command words into a transmit queue. Each word asks for one byte on the bus: a byte to write, or a byte to read. Flag bits in the word can add a repeated start before the byte and a stop after it. The sequencer inserts the start condition and the address phase whenever a new bus access begins. It then hands the engine one action at a time: start, write byte, read byte or stop. Each action uses a valid/done handshake. Bytes read from the bus land in a receive queue, which the host drains.

The target address comes from a configuration input. It is either a 7-bit address or a 10-bit address sent as two address bytes. Both queue fill levels are always visible, each with a threshold flag for the host's service logic. When a slave does not acknowledge a written byte, the transfer is aborted. Both queues are emptied, a stop is sent and a one-cycle abort pulse is raised.

When the queue runs dry and the last executed command carried no stop, the bus stays owned. The engine is expected to hold SCL low. The next command then continues the same transfer.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word carries the data byte in bits 7:0. Bit 8 = 1 selects a read, bit 9 = 1 requests a stop after the byte, and bit 10 = 1 requests a repeated start before it. Each command produces exactly one byte action: a write of bits 7:0 (eng_op 1) or a read (eng_op 2). The engine op codes are start 0, write 1, read 2 and stop 3.
- R2: The first command after the bus is idle is preceded by a start action and the address phase. In 7-bit mode (tgt_cfg bit 12 = 0) the address phase is one write of {tgt_cfg[6:0], read bit}.
- R3: In 10-bit mode (tgt_cfg bit 12 = 1) the address phase writes {11110, tgt_cfg[9:8], 0} and then tgt_cfg[7:0]. For a read it then adds a repeated start and the write {11110, tgt_cfg[9:8], 1}.
- R4: On an owned bus, a new start and address phase is inserted only when bit 10 is set or the direction differs from the previous byte. Otherwise the byte follows directly.
- R5: A command with bit 9 set is followed by a stop action. stop_det pulses for one cycle after the engine completes the stop, and the bus returns to idle.
- R6: When the queue empties after a command without a stop, bus_hold is high and no engine action is requested until a new command arrives.
- R7: For a read action, eng_mnak equals the command's stop bit: NACK on the last byte, ACK otherwise.
- R8: A read action is requested only while the receive queue has room. With a full receive queue the sequencer stalls until the host removes a byte.
- R9: Received bytes are delivered on rx_byte in the order they were read from the bus.
- R10: tx_lvl and rx_lvl give the entry counts and never exceed the depths. tx_low_flag is high while tx_lvl <= tx_thr, and rx_high_flag is high while rx_lvl > rx_thr, so a threshold of 0 flags the first byte.
- R11: If the engine reports no acknowledge on any written byte (address or data), abort pulses for one cycle. Both queues are empty on the next cycle, a stop action follows, and no queued command is executed.
- R12: Once raised, an engine request keeps eng_op, eng_wdata and eng_mnak stable until eng_done.
- R13: After reset both queues are empty, no engine request is raised and the bus is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Push cmd_word into the transmit queue |
| cmd_word | input | 11 | Command: data, read, stop, repeated-start flags |
| cmd_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Remove the head byte of the receive queue |
| rx_byte | output | 8 | Head byte of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| tgt_cfg | input | 13 | Target address in 9:0, bit 12 selects 10-bit mode |
| tx_thr | input | TX_LW | Transmit threshold |
| rx_thr | input | RX_LW | Receive threshold |
| tx_lvl | output | TX_LW | Transmit queue entry count |
| rx_lvl | output | RX_LW | Receive queue entry count |
| tx_low_flag | output | 1 | tx_lvl at or below tx_thr |
| rx_high_flag | output | 1 | rx_lvl above rx_thr |
| eng_valid | output | 1 | Engine action requested |
| eng_op | output | 2 | Action: 0 start, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Byte to write |
| eng_mnak | output | 1 | Master NACK for a read byte |
| eng_done | input | 1 | Engine finished the requested action |
| eng_nak | input | 1 | Written byte was not acknowledged (with eng_done) |
| eng_rdata | input | 8 | Byte read (with eng_done) |
| bus_hold | output | 1 | Bus owned and waiting for more commands |
| stop_det | output | 1 | One-cycle pulse when a stop has completed |
| abort | output | 1 | One-cycle pulse on a transfer abort |

## Verification
The assertions watch four things on every cycle:
- the queue levels stay within their bounds;
- no read is requested into a full receive queue;
- a request stays stable until the engine completes it;
- every stop_det follows a completed stop, and every abort empties both queues.

The exact action order can only be shown by the bench's scenarios, which compare the logged engine actions against an independent protocol model. This covers:
- the address bytes in both modes;
- which command boundaries insert a repeated start, and where stops fall;
- the ACK/NACK choice on reads;
- the stall with a full receive queue and its release;
- that queued commands are dropped after an abort.

// File: rtl/i2c_cseq_pkg.sv
package i2c_cseq_pkg;

    localparam int CMD_W    = 11;
    localparam int TGT_W    = 13;
    localparam int BIT_RD   = 8;
    localparam int BIT_STOP = 9;
    localparam int BIT_RS   = 10;
    localparam int BIT_TEN  = 12;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_WRITE = 2'd1,
        ENG_READ  = 2'd2,
        ENG_STOP  = 2'd3
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_BYTE,
        ST_STOP,
        ST_HOLD
    } seq_st_e;

    // address phase step
    localparam logic [1:0] STEP_HDR    = 2'd0;
    localparam logic [1:0] STEP_LOW    = 2'd1;
    localparam logic [1:0] STEP_HDR_RD = 2'd2;

    function automatic logic [7:0] addr_byte(input logic ten, input logic [9:0] a,
                                             input logic [1:0] step, input logic rd);
        logic [7:0] b;
        if (!ten) begin
            b = {a[6:0], rd};
        end else begin
            case (step)
                STEP_LOW:    b = a[7:0];
                STEP_HDR_RD: b = {5'b11110, a[9:8], 1'b1};
                default:     b = {5'b11110, a[9:8], 1'b0};
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/cseq_fifo.sv
module cseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] MAX_LVL  = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == MAX_LVL);
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];
    assign level   = q.cnt;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == LAST_IDX) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == LAST_IDX) ? '0 : q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[q.wp] <= wdata;
    end

endmodule

// File: rtl/cseq_lvl.sv
module cseq_lvl #(
    parameter int TX_LW = 4,
    parameter int RX_LW = 4
) (
    input  logic [TX_LW-1:0] tx_lvl,
    input  logic [TX_LW-1:0] tx_thr,
    input  logic [RX_LW-1:0] rx_lvl,
    input  logic [RX_LW-1:0] rx_thr,
    output logic             tx_low,
    output logic             rx_high
);
    always_comb begin
        tx_low  = (tx_lvl <= tx_thr);
        rx_high = (rx_lvl > rx_thr);
    end
endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
    import i2c_cseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_empty,
    input  logic [CMD_W-1:0] tx_head,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    input  logic [TGT_W-1:0] tgt_cfg,
    output logic             eng_valid,
    output eng_op_e          eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_mnak,
    input  logic             eng_done,
    input  logic             eng_nak,
    output logic             flush,
    output logic             stop_det,
    output logic             bus_hold
);
    typedef struct packed {
        seq_st_e          st;
        logic [CMD_W-1:0] cur;
        logic             ten;
        logic [9:0]       addr;
        logic [1:0]       step;
        logic             last_rd;
        logic             flush;
        logic             stop_det;
    } ctl_t;

    ctl_t q, d;
    logic cur_rd, head_rd, head_rs, fire;
    logic unused_bits;

    assign cur_rd      = q.cur[BIT_RD];
    assign head_rd     = tx_head[BIT_RD];
    assign head_rs     = tx_head[BIT_RS];
    assign unused_bits = q.cur[BIT_RS] ^ tgt_cfg[11] ^ tgt_cfg[10];

    // engine request decode
    always_comb begin
        eng_valid = 1'b0;
        eng_op    = ENG_START;
        eng_wdata = '0;
        eng_mnak  = 1'b0;
        case (q.st)
            ST_START: begin
                eng_valid = 1'b1;
                eng_op    = ENG_START;
            end
            ST_ADDR: begin
                eng_valid = 1'b1;
                eng_op    = ENG_WRITE;
                eng_wdata = addr_byte(q.ten, q.addr, q.step, cur_rd);
            end
            ST_BYTE: begin
                eng_valid = !(cur_rd && rx_full);
                eng_op    = cur_rd ? ENG_READ : ENG_WRITE;
                eng_wdata = q.cur[7:0];
                eng_mnak  = cur_rd && q.cur[BIT_STOP];
            end
            ST_STOP: begin
                eng_valid = 1'b1;
                eng_op    = ENG_STOP;
            end
            default: ;
        endcase
    end

    assign fire = eng_valid && eng_done;

    always_comb begin
        d          = q;
        d.flush    = 1'b0;
        d.stop_det = 1'b0;
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (!tx_empty) begin
                    tx_pop = 1'b1;
                    d.cur  = tx_head;
                    d.ten  = tgt_cfg[BIT_TEN];
                    d.addr = tgt_cfg[9:0];
                    d.step = STEP_HDR;
                    d.st   = ST_START;
                end
            end
            ST_HOLD: begin
                if (!tx_empty) begin
                    tx_pop = 1'b1;
                    d.cur  = tx_head;
                    if (head_rs || (head_rd != q.last_rd)) begin
                        d.step = STEP_HDR;
                        d.st   = ST_START;
                    end else begin
                        d.st = ST_BYTE;
                    end
                end
            end
            ST_START: begin
                if (fire) d.st = ST_ADDR;
            end
            ST_ADDR: begin
                if (fire) begin
                    if (eng_nak) begin
                        d.flush = 1'b1;
                        d.st    = ST_STOP;
                    end else if (!q.ten || q.step == STEP_HDR_RD) begin
                        d.st = ST_BYTE;
                    end else if (q.step == STEP_HDR) begin
                        d.step = STEP_LOW;
                    end else if (cur_rd) begin
                        d.step = STEP_HDR_RD;
                        d.st   = ST_START;
                    end else begin
                        d.st = ST_BYTE;
                    end
                end
            end
            ST_BYTE: begin
                if (fire) begin
                    if (!cur_rd && eng_nak) begin
                        d.flush = 1'b1;
                        d.st    = ST_STOP;
                    end else begin
                        rx_push   = cur_rd;
                        d.last_rd = cur_rd;
                        d.st      = q.cur[BIT_STOP] ? ST_STOP : ST_HOLD;
                    end
                end
            end
            ST_STOP: begin
                if (fire) begin
                    d.stop_det = 1'b1;
                    d.st       = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign flush    = q.flush;
    assign stop_det = q.stop_det;
    assign bus_hold = (q.st == ST_HOLD);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_cseq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int RX_LW   = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             cmd_full,
    input  logic             rx_rd,
    output logic [7:0]       rx_byte,
    output logic             rx_empty,
    input  logic [TGT_W-1:0] tgt_cfg,
    input  logic [TX_LW-1:0] tx_thr,
    input  logic [RX_LW-1:0] rx_thr,
    output logic [TX_LW-1:0] tx_lvl,
    output logic [RX_LW-1:0] rx_lvl,
    output logic             tx_low_flag,
    output logic             rx_high_flag,
    output logic             eng_valid,
    output logic [1:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_mnak,
    input  logic             eng_done,
    input  logic             eng_nak,
    input  logic [7:0]       eng_rdata,
    output logic             bus_hold,
    output logic             stop_det,
    output logic             abort
);
    logic             tx_empty, tx_pop, rx_full, rx_push, flush;
    logic [CMD_W-1:0] tx_head;
    eng_op_e          op_w;

    cseq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(cmd_wr), .wdata(cmd_word), .pop(tx_pop),
        .flush(flush), .rdata(tx_head), .level(tx_lvl), .full(cmd_full), .empty(tx_empty)
    );

    cseq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(eng_rdata), .pop(rx_rd),
        .flush(flush), .rdata(rx_byte), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    cseq_lvl #(.TX_LW(TX_LW), .RX_LW(RX_LW)) u_lvl (
        .tx_lvl(tx_lvl), .tx_thr(tx_thr), .rx_lvl(rx_lvl), .rx_thr(rx_thr),
        .tx_low(tx_low_flag), .rx_high(rx_high_flag)
    );

    cseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .tgt_cfg(tgt_cfg),
        .eng_valid(eng_valid), .eng_op(op_w), .eng_wdata(eng_wdata), .eng_mnak(eng_mnak),
        .eng_done(eng_done), .eng_nak(eng_nak), .flush(flush), .stop_det(stop_det),
        .bus_hold(bus_hold)
    );

    assign eng_op = op_w;
    assign abort  = flush;

endmodule

// File: rtl/cseq_chk.sv
module cseq_chk #(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int RX_LW   = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TX_LW-1:0] tx_lvl,
    input logic [RX_LW-1:0] rx_lvl,
    input logic             eng_valid,
    input logic [1:0]       eng_op,
    input logic [7:0]       eng_wdata,
    input logic             eng_mnak,
    input logic             eng_done,
    input logic             stop_det,
    input logic             abort
);
    localparam logic [TX_LW-1:0] TX_MAX = TX_LW'(TX_DEPTH);
    localparam logic [RX_LW-1:0] RX_MAX = RX_LW'(RX_DEPTH);

    assert_lvl_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= TX_MAX) && (rx_lvl <= RX_MAX));

    assert_read_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_op == 2'd2) |-> (rx_lvl < RX_MAX));

    assert_abort_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tx_lvl == '0) && (rx_lvl == '0));

    assert_stop_det_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |-> $past(eng_valid && eng_done && eng_op == 2'd3));

    assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_done) |=> eng_valid && $stable(eng_op) && $stable(eng_wdata)
                                     && $stable(eng_mnak));
endmodule

bind i2c_cmd_seq cseq_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .eng_valid(eng_valid),
    .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_mnak(eng_mnak), .eng_done(eng_done),
    .stop_det(stop_det), .abort(abort)
);

// File: tb/sim_i2c_cmd_seq.sv
`timescale 1ns/1ps
module sim_i2c_cmd_seq;
    localparam int TXD = 8;
    localparam int RXD = 8;
    localparam int TLW = $clog2(TXD + 1);
    localparam int RLW = $clog2(RXD + 1);
    localparam int OP_START = 0, OP_WRITE = 1, OP_READ = 2, OP_STOP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic [10:0] cmd_word = '0;
    logic cmd_full;
    logic rx_rd = 1'b0;
    logic [7:0] rx_byte;
    logic rx_empty;
    logic [12:0] tgt_cfg = '0;
    logic [TLW-1:0] tx_thr = '0;
    logic [RLW-1:0] rx_thr = '0;
    logic [TLW-1:0] tx_lvl;
    logic [RLW-1:0] rx_lvl;
    logic tx_low_flag, rx_high_flag, eng_valid, eng_mnak, bus_hold, stop_det, abort;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata;
    logic eng_done = 1'b0;
    logic eng_nak = 1'b0;
    logic [7:0] eng_rdata = '0;

    always #4 clk = ~clk;

    i2c_cmd_seq #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_full(cmd_full),
        .rx_rd(rx_rd), .rx_byte(rx_byte), .rx_empty(rx_empty), .tgt_cfg(tgt_cfg),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_low_flag(tx_low_flag), .rx_high_flag(rx_high_flag), .eng_valid(eng_valid),
        .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_mnak(eng_mnak), .eng_done(eng_done),
        .eng_nak(eng_nak), .eng_rdata(eng_rdata), .bus_hold(bus_hold),
        .stop_det(stop_det), .abort(abort)
    );

    int total = 0, bad = 0;
    int log_e [0:1023];
    int exp_e [0:1023];
    int log_n = 0, exp_n = 0;
    logic [7:0] rdq [0:255];
    int rdq_w = 0, rdq_r = 0;
    int nak_at = -1, wr_ops = 0, wait_c = 0;
    int n_abort = 0, n_stop = 0, flag_err = 0;
    bit eng_pause = 1'b0;
    bit m_open = 1'b0, m_last_rd = 1'b0;
    logic [12:0] m_tgt = '0;

    // engine model: answers one request at a time, acts on falling edges
    always @(negedge clk) begin
        if (eng_done) begin
            eng_done = 1'b0;
            eng_nak  = 1'b0;
        end else if (eng_valid && !eng_pause && rst_n) begin
            if (wait_c > 0) begin
                wait_c--;
            end else begin
                eng_done = 1'b1;
                case (int'(eng_op))
                    OP_WRITE: begin
                        log_e[log_n] = OP_WRITE * 512 + int'(eng_wdata);
                        eng_nak = (wr_ops == nak_at);
                        wr_ops++;
                    end
                    OP_READ: begin
                        log_e[log_n] = OP_READ * 512 + int'(eng_mnak);
                        eng_rdata = 8'($urandom);
                        rdq[rdq_w[7:0]] = eng_rdata;
                        rdq_w++;
                    end
                    default: log_e[log_n] = int'(eng_op) * 512;
                endcase
                log_n++;
                wait_c = $urandom % 3;
            end
        end
    end

    // flag and pulse monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_low_flag !== (tx_lvl <= tx_thr)) flag_err++;
            if (rx_high_flag !== (rx_lvl > rx_thr)) flag_err++;
            if (abort === 1'b1) n_abort++;
            if (stop_det === 1'b1) n_stop++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic exp_add(input int op, input int val);
        exp_e[exp_n] = op * 512 + val;
        exp_n++;
    endtask

    task automatic exp_addr(input bit rd);
        if (!m_tgt[12]) begin
            exp_add(OP_WRITE, int'({m_tgt[6:0], rd}));
        end else begin
            exp_add(OP_WRITE, int'({5'b11110, m_tgt[9:8], 1'b0}));
            exp_add(OP_WRITE, int'(m_tgt[7:0]));
            if (rd) begin
                exp_add(OP_START, 0);
                exp_add(OP_WRITE, int'({5'b11110, m_tgt[9:8], 1'b1}));
            end
        end
    endtask

    task automatic model_cmd(input bit rs, input bit stp, input bit rd, input logic [7:0] data);
        if (!m_open) begin
            exp_add(OP_START, 0);
            exp_addr(rd);
            m_open = 1'b1;
        end else if (rs || rd != m_last_rd) begin
            exp_add(OP_START, 0);
            exp_addr(rd);
        end
        if (rd) exp_add(OP_READ, int'(stp));
        else    exp_add(OP_WRITE, int'(data));
        m_last_rd = rd;
        if (stp) begin
            exp_add(OP_STOP, 0);
            m_open = 1'b0;
        end
    endtask

    task automatic push_cmd(input bit rs, input bit stp, input bit rd, input logic [7:0] data);
        while (cmd_full) @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = {rs, stp, rd, data};
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_cmd(input bit rs, input bit stp, input bit rd, input logic [7:0] data);
        model_cmd(rs, stp, rd, data);
        push_cmd(rs, stp, rd, data);
    endtask

    task automatic set_tgt(input logic [12:0] t);
        tgt_cfg = t;
        m_tgt   = t;
    endtask

    task automatic wait_quiet();
        int qc;
        qc = 0;
        while (qc < 6) begin
            @(negedge clk);
            if (!eng_valid && tx_lvl == '0 && !eng_done) qc++;
            else qc = 0;
        end
    endtask

    task automatic cmp_log(input string req);
        int mis;
        mis = 0;
        check(log_n == exp_n, {req, " action count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_e[i] != exp_e[i]) mis++;
        check(mis == 0, {req, " action sequence mismatches"}, mis, 0);
        log_n = 0;
        exp_n = 0;
    endtask

    task automatic drain_rx(input string req);
        int mis, pend;
        logic [7:0] b;
        mis  = 0;
        pend = rdq_w - rdq_r;
        check(int'(rx_lvl) == pend, {req, " rx level"}, int'(rx_lvl), pend);
        for (int i = 0; i < pend; i++) begin
            b = rx_byte;
            if (b !== rdq[rdq_r[7:0]]) mis++;
            rdq_r++;
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
        end
        check(mis == 0, {req, " rx data mismatches"}, mis, 0);
    endtask

    initial begin
        int seed_dummy;
        int ab0, st0, n;
        bit rd, rs, stp;
        seed_dummy = $urandom(32'h5eed);
        tx_thr = TLW'(2);
        rx_thr = '0;
        set_tgt(13'h0052);
        repeat (3) @(negedge clk);
        // R13 reset state
        check(tx_lvl == '0 && rx_lvl == '0, "R13 levels in reset", int'(tx_lvl) + int'(rx_lvl), 0);
        check(!eng_valid && !bus_hold, "R13 no request in reset", int'(eng_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_full && rx_empty && !eng_valid, "R13 after reset", int'(eng_valid), 0);

        // R1 R2 R5: 7-bit write with stop
        st0 = n_stop;
        do_cmd(0, 0, 0, 8'hA1);
        do_cmd(0, 1, 0, 8'h3C);
        wait_quiet();
        cmp_log("R1 R2 R5 write");
        check(n_stop == st0 + 1, "R5 stop_det count", n_stop - st0, 1);

        // R6 hold then continue without restart (R4)
        do_cmd(0, 0, 0, 8'h11);
        wait_quiet();
        check(bus_hold == 1'b1, "R6 bus held", int'(bus_hold), 1);
        cmp_log("R6 no stop issued");
        do_cmd(0, 1, 0, 8'h22);
        wait_quiet();
        cmp_log("R4 continue without start");
        check(bus_hold == 1'b0, "R5 bus released", int'(bus_hold), 0);

        // R4 direction change, R7, R10 rx flag, R9
        do_cmd(0, 0, 0, 8'h33);
        do_cmd(0, 1, 1, 8'h00);
        wait_quiet();
        cmp_log("R4 R7 direction change");
        rx_thr = '0;
        @(negedge clk);
        check(rx_high_flag == 1'b1, "R10 rx flag at threshold 0", int'(rx_high_flag), 1);
        rx_thr = RLW'(1);
        @(negedge clk);
        check(rx_high_flag == 1'b0, "R10 rx flag at threshold 1", int'(rx_high_flag), 0);
        rx_thr = '0;
        drain_rx("R9 single read");

        // R4 explicit restart same direction, R7 ack/nack
        do_cmd(0, 0, 1, 8'h00);
        do_cmd(1, 1, 1, 8'h00);
        wait_quiet();
        cmp_log("R4 R7 explicit restart");
        drain_rx("R9 two reads");

        // R3 10-bit write then read
        set_tgt(13'h1000 | 13'h02A5);
        do_cmd(0, 0, 0, 8'h5A);
        do_cmd(0, 1, 1, 8'h00);
        wait_quiet();
        cmp_log("R3 ten-bit address");
        drain_rx("R9 ten-bit read");

        // R10 transmit threshold with engine paused
        set_tgt(13'h0041);
        eng_pause = 1'b1;
        do_cmd(0, 0, 0, 8'h01);
        do_cmd(0, 0, 0, 8'h02);
        do_cmd(0, 0, 0, 8'h03);
        do_cmd(0, 1, 0, 8'h04);
        check(int'(tx_lvl) == 3, "R10 tx level", int'(tx_lvl), 3);
        check(tx_low_flag == 1'b0, "R10 tx flag above threshold", int'(tx_low_flag), 0);
        tx_thr = TLW'(3);
        @(negedge clk);
        check(tx_low_flag == 1'b1, "R10 tx flag at threshold", int'(tx_low_flag), 1);
        eng_pause = 1'b0;
        wait_quiet();
        cmp_log("R1 paused burst");

        // R8 receive stall
        for (int i = 0; i < RXD; i++) do_cmd(0, 0, 1, 8'h00);
        wait_quiet();
        check(int'(rx_lvl) == RXD, "R8 rx full", int'(rx_lvl), RXD);
        do_cmd(0, 1, 1, 8'h00);
        repeat (20) @(negedge clk);
        check(!eng_valid && int'(rx_lvl) == RXD && log_n == 10, "R8 read stalled",
              log_n, 10);
        begin
            logic [7:0] b;
            b = rx_byte;
            check(b === rdq[rdq_r[7:0]], "R9 first stalled byte", int'(b), int'(rdq[rdq_r[7:0]]));
            rdq_r++;
            rx_rd = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0;
        end
        wait_quiet();
        cmp_log("R8 stall released");
        drain_rx("R9 after stall");

        // R11 abort on address nack, rx holds data
        set_tgt(13'h0030);
        ab0 = n_abort;
        st0 = n_stop;
        nak_at = wr_ops + 1;
        do_cmd(0, 0, 1, 8'h00);
        do_cmd(0, 0, 1, 8'h00);
        push_cmd(0, 0, 0, 8'h77);
        push_cmd(0, 1, 0, 8'h78);
        exp_add(OP_START, 0);
        exp_add(OP_WRITE, int'({7'h30, 1'b0}));
        exp_add(OP_STOP, 0);
        m_open = 1'b0;
        wait_quiet();
        nak_at = -1;
        check(n_abort == ab0 + 1, "R11 abort pulse", n_abort - ab0, 1);
        check(n_stop == st0 + 1, "R11 stop after abort", n_stop - st0, 1);
        check(tx_lvl == '0 && rx_lvl == '0 && rx_empty, "R11 queues flushed",
              int'(tx_lvl) + int'(rx_lvl), 0);
        cmp_log("R11 no queued command executed");
        rdq_r = rdq_w;

        // random sequences
        for (int it = 0; it < 24; it++) begin
            if (!m_open) begin
                logic [12:0] t;
                t = 13'($urandom) & 13'h03FF;
                if ($urandom % 2 == 1) t = t | 13'h1000;
                else t = t & 13'h007F;
                set_tgt(t);
            end
            n = 1 + $urandom % 6;
            for (int k = 0; k < n; k++) begin
                rd  = ($urandom % 2) == 1;
                rs  = ($urandom % 4) == 0;
                stp = (k == n - 1) && (($urandom % 4) != 0 || it == 23);
                do_cmd(rs, stp, rd, 8'($urandom));
            end
            wait_quiet();
            cmp_log("R1 R4 random");
            drain_rx("R9 random");
        end

        check(flag_err == 0, "R10 flag rule every cycle", flag_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule